// File: doc/BRIEF.md
# Gated / Event Pulse Accumulator

This block is an 8-bit pulse accumulator. One asynchronous input pin feeds it, and the bus clock runs it. It has two operating modes, picked by a configuration bit. In event mode it counts one chosen edge of the pin. In gated mode it counts a free-running time base of one tick every 64 bus clocks, but only while the pin is at its counting level. A single polarity bit serves both modes:

- In event mode the polarity bit picks the counting edge.
- In gated mode it picks the level that blocks counting.

Software can load the counter at any time and sees its value at all times. Two sticky flags report conditions to software:

- An input-edge flag sets on the chosen edge. In gated mode that is the edge that closes the gate.
- An overflow flag sets when the counter wraps from 255 to 0.

Each flag has its own interrupt enable. Software clears a flag by a write-one-to-clear strobe.

The pin passes through a two-stage synchroniser before edge detection. Control is a four-state machine:

- `ST_OFF`: the block is disabled.
- `ST_EVENT`: event counting.
- `ST_GATE_RUN`: gated mode with the gate open.
- `ST_GATE_HOLD`: gated mode with the gate closed.

Every state takes these transitions, which are checked in order:

1. Any state goes to `ST_OFF` when the enable is low.
2. With the enable high, any state goes to `ST_EVENT` when the mode bit selects event counting.
3. With the enable high and gated mode selected, the state goes to `ST_GATE_RUN` when the synchronised pin is at its counting level, and to `ST_GATE_HOLD` otherwise.

Top module: `pulse_accum`

## Requirements
- R1: After reset the counter reads 0, both flags read 0 and the interrupt output is low.
- R2: While the enable input is low, pin activity neither changes the counter nor sets the edge flag. Counter writes are still accepted.
- R3: In event mode (mode input 0), polarity 0 counts falling pin edges and polarity 1 counts rising pin edges. The other edge is ignored.
- R4: In gated mode (mode input 1), the counter advances by one per 64 bus clocks while the synchronised pin is at its counting level. Polarity 0 blocks counting while the pin is low. Polarity 1 blocks counting while the pin is high. A gate held open for 640 bus clocks adds exactly 10.
- R5: With the block enabled, the edge flag sets on a falling pin edge when the polarity is 0 and on a rising pin edge when the polarity is 1, in both modes.
- R6: An increment from 255 wraps the counter to 0 and sets the overflow flag.
- R7: A clear strobe clears the edge flag where mask bit 0 is 1 and the overflow flag where mask bit 1 is 1. A flag whose mask bit is 0 is left as it is. A flag set in the same cycle as its clear stays set.
- R8: A counter write loads the written value on the next clock. A write in the same cycle as an increment wins, and that increment is dropped.
- R9: The interrupt output is high exactly when some flag is set and its own enable input is high.
- R10: A pin toggling on every bus clock (a rate of bus clock / 2) has each selected edge counted exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Asynchronous accumulator input |
| cfg_enable | input | 1 | Accumulator on |
| cfg_gated | input | 1 | 0 = event counting, 1 = gated time accumulation |
| cfg_pol | input | 1 | Edge select (event) or inhibit level select (gated) |
| cnt_wr_en | input | 1 | Counter load strobe |
| cnt_wr_data | input | 8 | Value to load |
| cnt_q | output | 8 | Current counter value |
| flag_clr_en | input | 1 | Flag clear strobe |
| flag_clr_mask | input | 2 | Bit 0 clears edge flag, bit 1 clears overflow flag |
| ie_edge | input | 1 | Edge flag interrupt enable |
| ie_ovf | input | 1 | Overflow flag interrupt enable |
| flag_edge | output | 1 | Input-edge flag |
| flag_ovf | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
A software counter load and a counted edge can land on the same clock edge. In that same cycle, a clear strobe for the edge flag can meet the edge that sets it. The bench provokes both together. It raises the pin half a cycle before a clock edge and asserts the load and the clear strobe two clock edges later, which is the cycle in which the synchronised rise is seen. The result is judged at the ports: the counter must hold exactly the loaded value with no increment added, and the edge flag must still read 1.

// File: rtl/pa_pkg.sv
package pa_pkg;

    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_EVENT     = 2'd1,
        ST_GATE_RUN  = 2'd2,
        ST_GATE_HOLD = 2'd3
    } pa_state_e;

    localparam int FLAG_EDGE_IDX = 0;
    localparam int FLAG_OVF_IDX  = 1;
    localparam int FLAG_COUNT    = 2;

endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES < 2) begin : g_bad
            initial $fatal(1, "SYNC_STAGES must be at least 2");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign level_o = sync_q[SYNC_STAGES-1];
    assign rise_o  = level_o & ~prev_q;
    assign fall_o  = ~level_o & prev_q;

    AST_EDGE_FOLLOWS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o) else $error("rise seen twice in a row"); // R10

endmodule

// File: rtl/pa_prescaler.sv
module pa_prescaler #(
    parameter int DIV_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    logic [DIV_LOG2-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign tick_o = &div_q;

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o) else $error("back-to-back ticks"); // R4

endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             inc_i,
    output logic [WIDTH-1:0] q_o,
    output logic             wrap_o
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (wr_en_i) cnt_q <= wr_data_i;
        else if (inc_i)   cnt_q <= cnt_q + 1'b1;
    end

    assign q_o    = cnt_q;
    assign wrap_o = inc_i & ~wr_en_i & (&cnt_q);

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> q_o == $past(wr_data_i)) else $error("write lost"); // R8
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> q_o == '0) else $error("wrap not to zero"); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !inc_i) |=> $stable(q_o)) else $error("counter drifted"); // R2

endmodule

// File: rtl/pa_ctrl.sv
module pa_ctrl
    import pa_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_enable_i,
    input  logic                  cfg_gated_i,
    input  logic                  cfg_pol_i,
    input  logic                  level_i,
    input  logic                  rise_i,
    input  logic                  fall_i,
    input  logic                  tick_i,
    input  logic                  wrap_i,
    input  logic                  clr_en_i,
    input  logic [FLAG_COUNT-1:0] clr_mask_i,
    input  logic                  ie_edge_i,
    input  logic                  ie_ovf_i,
    output logic                  inc_o,
    output logic                  flag_edge_o,
    output logic                  flag_ovf_o,
    output logic                  irq_o
);
    pa_state_e state_q, state_d;
    logic      gate_open;
    logic      sel_edge;
    logic      set_edge, set_ovf;
    logic      clr_edge, clr_ovf;
    logic      flag_edge_q, flag_ovf_q;

    assign gate_open = cfg_pol_i ? ~level_i : level_i;
    assign sel_edge  = cfg_pol_i ? rise_i : fall_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (cfg_enable_i)
                    state_d = !cfg_gated_i ? ST_EVENT :
                              (gate_open ? ST_GATE_RUN : ST_GATE_HOLD);
            end
            ST_EVENT: begin
                if (!cfg_enable_i)    state_d = ST_OFF;
                else if (cfg_gated_i) state_d = gate_open ? ST_GATE_RUN : ST_GATE_HOLD;
            end
            ST_GATE_RUN: begin
                if (!cfg_enable_i)     state_d = ST_OFF;
                else if (!cfg_gated_i) state_d = ST_EVENT;
                else if (!gate_open)   state_d = ST_GATE_HOLD;
            end
            ST_GATE_HOLD: begin
                if (!cfg_enable_i)     state_d = ST_OFF;
                else if (!cfg_gated_i) state_d = ST_EVENT;
                else if (gate_open)    state_d = ST_GATE_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        inc_o = 1'b0;
        unique case (state_q)
            ST_EVENT:     inc_o = sel_edge;
            ST_GATE_RUN:  inc_o = tick_i;
            ST_OFF,
            ST_GATE_HOLD: inc_o = 1'b0;
            default:      inc_o = 1'b0;
        endcase
    end

    assign set_edge = cfg_enable_i & sel_edge;
    assign set_ovf  = wrap_i;
    assign clr_edge = clr_en_i & clr_mask_i[FLAG_EDGE_IDX];
    assign clr_ovf  = clr_en_i & clr_mask_i[FLAG_OVF_IDX];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_edge_q <= 1'b0;
            flag_ovf_q  <= 1'b0;
        end else begin
            flag_edge_q <= set_edge | (flag_edge_q & ~clr_edge);
            flag_ovf_q  <= set_ovf  | (flag_ovf_q  & ~clr_ovf);
        end
    end

    assign flag_edge_o = flag_edge_q;
    assign flag_ovf_o  = flag_ovf_q;
    assign irq_o       = (flag_edge_q & ie_edge_i) | (flag_ovf_q & ie_ovf_i);

    AST_EDGE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_edge |=> flag_edge_o) else $error("edge flag missed"); // R5
    AST_OVF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> flag_ovf_o) else $error("overflow flag missed"); // R6
    AST_CLEAR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_edge && !set_edge) |=> !flag_edge_o) else $error("edge flag not cleared"); // R7
    AST_OFF_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable_i |=> state_q == ST_OFF) else $error("not off when disabled"); // R2

endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
    import pa_pkg::*;
#(
    parameter int CNT_WIDTH   = 8,
    parameter int DIV_LOG2    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pin_in,
    input  logic                  cfg_enable,
    input  logic                  cfg_gated,
    input  logic                  cfg_pol,
    input  logic                  cnt_wr_en,
    input  logic [CNT_WIDTH-1:0]  cnt_wr_data,
    output logic [CNT_WIDTH-1:0]  cnt_q,
    input  logic                  flag_clr_en,
    input  logic [FLAG_COUNT-1:0] flag_clr_mask,
    input  logic                  ie_edge,
    input  logic                  ie_ovf,
    output logic                  flag_edge,
    output logic                  flag_ovf,
    output logic                  irq
);
    logic lvl, rise, fall, tick, inc, wrap;

    pa_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_in),
        .level_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    pa_prescaler #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    pa_counter #(.WIDTH(CNT_WIDTH)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr_en_i(cnt_wr_en), .wr_data_i(cnt_wr_data),
        .inc_i(inc), .q_o(cnt_q), .wrap_o(wrap)
    );

    pa_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_enable_i(cfg_enable), .cfg_gated_i(cfg_gated), .cfg_pol_i(cfg_pol),
        .level_i(lvl), .rise_i(rise), .fall_i(fall), .tick_i(tick), .wrap_i(wrap),
        .clr_en_i(flag_clr_en), .clr_mask_i(flag_clr_mask),
        .ie_edge_i(ie_edge), .ie_ovf_i(ie_ovf),
        .inc_o(inc), .flag_edge_o(flag_edge), .flag_ovf_o(flag_ovf), .irq_o(irq)
    );

endmodule

// File: tb/sim_pulse_accum.sv
module sim_pulse_accum;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {pol, pulses[7:0], start[7:0], expect[7:0], expect_ovf}
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b0, 8'd5,  8'h00, 8'h05, 1'b0},
        {1'b1, 8'd7,  8'h10, 8'h17, 1'b0},
        {1'b0, 8'd3,  8'hFE, 8'h01, 1'b1},
        {1'b1, 8'd1,  8'hFF, 8'h00, 1'b1},
        {1'b0, 8'd0,  8'h33, 8'h33, 1'b0},
        {1'b1, 8'd12, 8'h80, 8'h8C, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_in = 1'b0;
    logic cfg_enable = 1'b0, cfg_gated = 1'b0, cfg_pol = 1'b0;
    logic cnt_wr_en = 1'b0;
    logic [7:0] cnt_wr_data = 8'h00;
    logic [7:0] cnt_q;
    logic flag_clr_en = 1'b0;
    logic [1:0] flag_clr_mask = 2'b00;
    logic ie_edge = 1'b0, ie_ovf = 1'b0;
    logic flag_edge, flag_ovf, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_accum u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .cfg_enable(cfg_enable), .cfg_gated(cfg_gated), .cfg_pol(cfg_pol),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .cnt_q(cnt_q),
        .flag_clr_en(flag_clr_en), .flag_clr_mask(flag_clr_mask),
        .ie_edge(ie_edge), .ie_ovf(ie_ovf),
        .flag_edge(flag_edge), .flag_ovf(flag_ovf), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] v);
        cnt_wr_data = v; cnt_wr_en = 1'b1;
        @(negedge clk);
        cnt_wr_en = 1'b0;
    endtask

    task automatic clear(input logic [1:0] m);
        flag_clr_mask = m; flag_clr_en = 1'b1;
        @(negedge clk);
        flag_clr_en = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pin_in = 1'b1; cycles(3);
            pin_in = 1'b0; cycles(3);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cnt", cnt_q, 0);
        chk("R1 flags", {flag_edge, flag_ovf}, 0);
        chk("R1 irq", irq, 0);

        // R3 R5 R6 table of event-mode vectors
        cfg_enable = 1'b1; cfg_gated = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            cfg_pol = VEC[v][25];
            cycles(3);
            clear(2'b11);
            load(VEC[v][16:9]);
            pulses(int'(VEC[v][24:17]));
            cycles(6);
            chk("R3 event count", cnt_q, int'(VEC[v][8:1]));
            chk("R6 overflow flag", flag_ovf, int'(VEC[v][0]));
            chk("R5 edge flag", flag_edge, int'(VEC[v][24:17] != 0));
        end

        // R7 mask bit 1 only clears overflow, edge flag kept
        load(8'hFF); pulses(1); cycles(6);
        clear(2'b10);
        chk("R7 ovf cleared", flag_ovf, 0);
        chk("R7 edge kept", flag_edge, 1);
        clear(2'b01);
        chk("R7 edge cleared", flag_edge, 0);

        // R9 interrupt from enables
        load(8'hFF); pulses(1); cycles(6);
        clear(2'b01);
        chk("R9 irq masked", irq, 0);
        ie_ovf = 1'b1; #1;
        chk("R9 irq ovf", irq, 1);
        ie_ovf = 1'b0; ie_edge = 1'b1; #1;
        chk("R9 irq edge-enable with clear flag", irq, 0);
        ie_edge = 1'b0;
        clear(2'b11);

        // R8 R7 write and clear collide with a counted rise
        cfg_pol = 1'b1; cycles(3);
        load(8'h05);
        pin_in = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        cnt_wr_data = 8'h40; cnt_wr_en = 1'b1;
        flag_clr_mask = 2'b01; flag_clr_en = 1'b1;
        @(negedge clk);
        cnt_wr_en = 1'b0; flag_clr_en = 1'b0;
        chk("R8 write beats increment", cnt_q, 8'h40);
        chk("R7 set wins over clear", flag_edge, 1);
        pin_in = 1'b0; cycles(6);
        chk("R3 falling ignored pol1", cnt_q, 8'h40);

        // R10 pin toggling every clock
        clear(2'b11); load(8'h00);
        for (int i = 0; i < 20; i++) begin
            pin_in = ~pin_in; @(negedge clk);
        end
        cycles(6);
        chk("R10 half rate count", cnt_q, 10);

        // R2 disabled
        cfg_enable = 1'b0; cycles(3);
        load(8'h22); clear(2'b11);
        chk("R2 write while off", cnt_q, 8'h22);
        cfg_pol = 1'b0; pulses(3);
        cfg_pol = 1'b1; pulses(3);
        cycles(6);
        chk("R2 no count while off", cnt_q, 8'h22);
        chk("R2 no flag while off", flag_edge, 0);

        // R4 R5 gated, polarity 0: low inhibits
        cfg_enable = 1'b1; cfg_gated = 1'b1; cfg_pol = 1'b0;
        cycles(3); load(8'h00); clear(2'b11);
        cycles(640);
        chk("R4 low inhibits pol0", cnt_q, 0);
        pin_in = 1'b1; cycles(640);
        chk("R5 no flag on gate open pol0", flag_edge, 0);
        pin_in = 1'b0; cycles(6);
        chk("R4 gated pol0 count", cnt_q, 10);
        chk("R5 trailing edge flag pol0", flag_edge, 1);

        // R4 R5 gated, polarity 1: high inhibits
        clear(2'b11); load(8'h00);
        cfg_pol = 1'b1;
        cycles(640);
        pin_in = 1'b1; cycles(6);
        chk("R4 gated pol1 count", cnt_q, 10);
        chk("R5 trailing edge flag pol1", flag_edge, 1);
        cycles(640);
        chk("R4 high inhibits pol1", cnt_q, 10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule